// File: doc/BRIEF.md
# Four-Phase Dual-Rail Pulse Pipeline

This block is a cycle-accurate digital model of a pipeline built in the two-level adiabatic style. A small generator steps through four ticks per cycle and produces four overlapping phase clocks. Each phase is high for two ticks in a row. Behind the generator sits a chain of dual-rail stages. Each stage is clocked by the phase whose number equals its index modulo four. A data pulse therefore moves forward one stage per tick, and it stays two ticks wide at every stage.

A logical bit travels on two rails: a true rail and a false rail. A valid value pulses exactly one of the two. Ticks advance only on clock cycles where the tick strobe is high, so the pipeline runs at any rate below the system clock. Each stage applies a fixed function chosen by a parameter: buffer, inverter (the two rails are simply swapped, with no logic), dual-rail AND, or dual-rail OR. The AND and OR stages combine the previous stage with a shared side operand. A sticky flag records any stage that has both rails high at once.

Top module: `dual_rail_pulse_pipe`

## Requirements
- R1: The tick counter holds a value from 0 to 3 and advances by one (wrapping) on each clock where `tick_en` is high. The first tick after a clear or a reset enters tick 0, and the phase vector then reads 4'b1001.
- R2: Phase i is high exactly during ticks i and (i+1) mod 4. While the generator runs, exactly two adjacent phases are high, and the vector rotates left by one position on every tick.
- R3: On a clock with `tick_en` low and `clr` low, the phases and all stage rails keep their values.
- R4: Stage k captures its input on the tick that enters tick (k mod 4), holds it for that tick and the next, and returns both rails low on the tick that enters ((k+2) mod 4). Stage 0's input is `din`, and stage k's input is stage k-1.
- R5: A stage whose input carries no pulse when it captures keeps both of its rails low for that window.
- R6: An inverting stage outputs its input with the rails swapped. Bit 1 of each rail pair is the true rail, and bit 0 is the false rail. In the default configuration, stage 2 inverts.
- R7: An AND stage outputs true = a.true AND b.true, and false = a.false OR b.false. An OR stage outputs true = a.true OR b.true, and false = a.false AND b.false. Here a is the previous stage and b is `side`. By default, stage 5 is AND and stage 6 is OR. Function codes: 0 buffer, 1 invert, 2 AND, 3 OR, two bits per stage.
- R8: If both rails of any stage are high, `enc_err` rises on the next clock and stays high until `clr` or reset.
- R9: `clr`, or an asserted `rst_n`, sets the tick counter to its idle state, drives all phases and rails low, and clears `enc_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of ticks, rails and flag |
| tick_en | input | 1 | Advances the pipeline by one tick when high |
| din | input | 2 | Dual-rail data into stage 0 ({true,false}) |
| side | input | 2 | Dual-rail second operand for AND/OR stages |
| phase | output | 4 | Four overlapping phase clocks |
| stage_rails | output | 2*DEPTH | Rail pairs of all stages; stage k at bits [2k+1:2k] |
| enc_err | output | 1 | Sticky flag: both rails of a stage were high |

## Verification
A directed pulse of logic 1 is sent down the chain. It shows that each stage captures one tick after the one before it, that a pulse is cleared after two ticks, and that the rails swap at the inverting stage. Chosen side values then show that AND and OR each produce a distinct result. Long stretches with the strobe held low separate true tick gating from a design that simply follows the clock. Random streams mix empty windows, both data values, random strobes and occasional clears against a behavioural model compared on every clock. A final injection of both rails high checks that the flag is set, that it is sticky, and that a clear removes it.

// File: rtl/dual_rail_pulse_pipe_pkg.sv
package dual_rail_pulse_pipe_pkg;

  localparam int NUM_PHASES = 4;

  typedef enum logic [1:0] {
    OP_BUF = 2'd0,
    OP_INV = 2'd1,
    OP_AND = 2'd2,
    OP_OR  = 2'd3
  } stage_op_e;

  // bit 1 = true rail, bit 0 = false rail
  typedef logic [1:0] dual_t;

  function automatic dual_t apply_op(input stage_op_e op, input dual_t a, input dual_t b);
    dual_t r;
    case (op)
      OP_INV:  r = {a[0], a[1]};
      OP_AND:  r = {a[1] & b[1], a[0] | b[0]};
      OP_OR:   r = {a[1] | b[1], a[0] & b[0]};
      default: r = a;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pp_rst_sync.sv
module pp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pp_phase_gen.sv
module pp_phase_gen
  import dual_rail_pulse_pipe_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  tick_en,
  output logic [NUM_PHASES-1:0] phase,
  output logic [NUM_PHASES-1:0] rise,
  output logic [NUM_PHASES-1:0] fall
);
  localparam int TW = $clog2(NUM_PHASES);

  logic          live_q, live_d;
  logic [TW-1:0] tick_q, tick_d, tick_enter;
  logic          step;

  assign step       = tick_en && !clr;
  assign tick_enter = live_q ? tick_q + TW'(1) : '0;

  always_comb begin
    live_d = live_q;
    tick_d = tick_q;
    if (clr) begin
      live_d = 1'b0;
      tick_d = '0;
    end else if (tick_en) begin
      live_d = 1'b1;
      tick_d = tick_enter;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      tick_q <= '0;
    end else begin
      live_q <= live_d;
      tick_q <= tick_d;
    end
  end

  for (genvar i = 0; i < NUM_PHASES; i++) begin : g_phase
    localparam logic [TW-1:0] T_ON   = TW'(i);
    localparam logic [TW-1:0] T_HOLD = TW'((i + 1) % NUM_PHASES);
    localparam logic [TW-1:0] T_OFF  = TW'((i + 2) % NUM_PHASES);
    assign phase[i] = live_q && ((tick_q == T_ON) || (tick_q == T_HOLD));
    assign rise[i]  = step && (tick_enter == T_ON);
    assign fall[i]  = step && (tick_enter == T_OFF);
  end
endmodule

// File: rtl/pp_rail_stage.sv
module pp_rail_stage
  import dual_rail_pulse_pipe_pkg::*;
#(
  parameter stage_op_e OP = OP_BUF
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  take,
  input  logic  drop,
  input  dual_t a,
  input  dual_t b,
  output dual_t q
);
  dual_t q_d;

  always_comb begin
    q_d = q;
    if (clr)       q_d = 2'b00;
    else if (take) q_d = apply_op(OP, a, b);
    else if (drop) q_d = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 2'b00;
    else        q <= q_d;
  end
endmodule

// File: rtl/pp_err_mon.sv
module pp_err_mon #(
  parameter int DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [2*DEPTH-1:0] rails,
  output logic               err
);
  logic both_hi;
  logic err_d;

  always_comb begin
    both_hi = 1'b0;
    for (int k = 0; k < DEPTH; k++) both_hi = both_hi | (rails[2*k] & rails[2*k+1]);
    err_d = clr ? 1'b0 : (err | both_hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= err_d;
  end
endmodule

// File: rtl/dual_rail_pulse_pipe.sv
module dual_rail_pulse_pipe
  import dual_rail_pulse_pipe_pkg::*;
#(
  parameter int               DEPTH     = 8,
  parameter logic [2*DEPTH-1:0] STAGE_OPS = 16'h3810
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               tick_en,
  input  logic [1:0]         din,
  input  logic [1:0]         side,
  output logic [3:0]         phase,
  output logic [2*DEPTH-1:0] stage_rails,
  output logic               enc_err
);
  logic                  rst_core_n;
  logic [NUM_PHASES-1:0] rise, fall;
  dual_t                 st_q [DEPTH];

  pp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  pp_phase_gen u_phase (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .clr     (clr),
    .tick_en (tick_en),
    .phase   (phase),
    .rise    (rise),
    .fall    (fall)
  );

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    localparam int        PH  = k % NUM_PHASES;
    localparam stage_op_e SOP = stage_op_e'(STAGE_OPS[2*k +: 2]);
    dual_t a_in;
    if (k == 0) begin : g_head
      assign a_in = din;
    end else begin : g_link
      assign a_in = st_q[k-1];
    end
    pp_rail_stage #(.OP(SOP)) u_st (
      .clk   (clk),
      .rst_n (rst_core_n),
      .clr   (clr),
      .take  (rise[PH]),
      .drop  (fall[PH]),
      .a     (a_in),
      .b     (side),
      .q     (st_q[k])
    );
    assign stage_rails[2*k +: 2] = st_q[k];
  end

  pp_err_mon #(.DEPTH(DEPTH)) u_err (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clr   (clr),
    .rails (stage_rails),
    .err   (enc_err)
  );
endmodule

// File: rtl/dual_rail_pulse_pipe_chk.sv
module dual_rail_pulse_pipe_chk #(
  parameter int DEPTH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr,
  input logic               tick_en,
  input logic [3:0]         phase,
  input logic [2*DEPTH-1:0] stage_rails,
  input logic               enc_err
);
  logic any_both;
  always_comb begin
    any_both = 1'b0;
    for (int k = 0; k < DEPTH; k++) any_both = any_both | (stage_rails[2*k] & stage_rails[2*k+1]);
  end

  assert_first_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !clr && phase == 4'b0000 && $past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3))
      |=> phase == 4'b1001);

  assert_rotate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !clr && phase != 4'b0000) |=> phase == {$past(phase[2:0]), $past(phase[3])});

  assert_two_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 4'b0000) |-> $countones(phase) == 2);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !clr) |=> ($stable(phase) && $stable(stage_rails)));

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (any_both && !clr) |=> enc_err);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_err && !clr) |=> enc_err);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (phase == 4'b0000 && stage_rails == '0 && !enc_err));
endmodule

bind dual_rail_pulse_pipe dual_rail_pulse_pipe_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr         (clr),
  .tick_en     (tick_en),
  .phase       (phase),
  .stage_rails (stage_rails),
  .enc_err     (enc_err)
);

// File: tb/tb_dual_rail_pulse_pipe.sv
module tb_dual_rail_pulse_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clr;
  logic          tick_en;
  logic [1:0]    din;
  logic [1:0]    side;
  logic [3:0]    phase;
  logic [2*N-1:0] stage_rails;
  logic          enc_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  logic [1:0] m_rail [N];
  bit         m_live;
  int         m_tick;
  bit         m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_rail_pulse_pipe dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick_en(tick_en),
    .din(din), .side(side), .phase(phase), .stage_rails(stage_rails), .enc_err(enc_err)
  );

  function automatic logic [1:0] ref_fn(int k, logic [1:0] a, logic [1:0] b);
    if (k == 2) return {a[0], a[1]};
    if (k == 5) return {a[1] & b[1], a[0] | b[0]};
    if (k == 6) return {a[1] | b[1], a[0] & b[0]};
    return a;
  endfunction

  task automatic check(string req, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < N; k++) m_rail[k] = 2'b00;
    m_live = 0; m_tick = 0; m_err = 0;
  endtask

  task automatic model_step();
    logic [1:0] old [N];
    int nt;
    if (clr) begin
      model_reset();
      return;
    end
    for (int k = 0; k < N; k++) begin
      old[k] = m_rail[k];
      if (m_rail[k] == 2'b11) m_err = 1;
    end
    if (tick_en) begin
      nt = m_live ? (m_tick + 1) % 4 : 0;
      for (int k = 0; k < N; k++) begin
        if (k % 4 == nt)            m_rail[k] = ref_fn(k, (k == 0) ? din : old[k-1], side);
        else if ((k + 2) % 4 == nt) m_rail[k] = 2'b00;
      end
      m_tick = nt;
      m_live = 1;
    end
  endtask

  function automatic logic [3:0] exp_phase();
    logic [3:0] p = 4'b0000;
    if (m_live)
      for (int i = 0; i < 4; i++) if (((m_tick - i + 4) % 4) < 2) p[i] = 1'b1;
    return p;
  endfunction

  task automatic compare_all();
    logic [3:0] ep = exp_phase();
    check("R2", phase == ep, phase, ep);
    check("R8", enc_err == m_err, enc_err, m_err);
    for (int k = 0; k < N; k++) begin
      string tag = (k == 2) ? "R6" : ((k == 5 || k == 6) ? "R7" : "R4");
      check(tag, stage_rails[2*k +: 2] == m_rail[k], stage_rails[2*k +: 2], m_rail[k]);
    end
  endtask

  task automatic cycle(bit c, bit en, logic [1:0] d, logic [1:0] s);
    @(negedge clk);
    clr = c; tick_en = en; din = d; side = s;
    model_step();
    @(posedge clk);
    #2;
    compare_all();
  endtask

  function automatic logic [1:0] rand_val();
    int r = $urandom_range(0, 2);
    return (r == 0) ? 2'b00 : ((r == 1) ? 2'b01 : 2'b10);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; clr = 0; tick_en = 0; din = 2'b00; side = 2'b00;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    // R9: reset state
    check("R9", phase == 4'b0000, phase, 0);
    check("R9", stage_rails == '0, stage_rails, 0);
    check("R9", enc_err == 1'b0, enc_err, 0);

    // R1: first tick enters tick 0, stage 0 captures a logic 1
    cycle(0, 1, 2'b10, 2'b00);
    check("R1", phase == 4'b1001, phase, 4'b1001);
    check("R4", stage_rails[1:0] == 2'b10, stage_rails[1:0], 2'b10);
    // R3: strobe low holds everything
    for (int j = 0; j < 3; j++) begin
      cycle(0, 0, 2'b01, 2'b01);
      check("R3", phase == 4'b1001, phase, 4'b1001);
      check("R3", stage_rails[1:0] == 2'b10, stage_rails[1:0], 2'b10);
    end
    cycle(0, 1, 2'b00, 2'b00);   // tick 1
    check("R4", stage_rails[3:2] == 2'b10, stage_rails[3:2], 2'b10);
    cycle(0, 1, 2'b00, 2'b00);   // tick 2
    check("R6", stage_rails[5:4] == 2'b01, stage_rails[5:4], 2'b01);
    check("R4", stage_rails[1:0] == 2'b00, stage_rails[1:0], 2'b00);
    cycle(0, 1, 2'b00, 2'b00);   // tick 3
    cycle(0, 1, 2'b00, 2'b00);   // tick 0, empty input window
    check("R5", stage_rails[1:0] == 2'b00, stage_rails[1:0], 2'b00);
    cycle(0, 1, 2'b00, 2'b10);   // tick 1: AND(01,10) = 01
    check("R7", stage_rails[11:10] == 2'b01, stage_rails[11:10], 2'b01);
    cycle(0, 1, 2'b00, 2'b10);   // tick 2: OR(01,10) = 10
    check("R7", stage_rails[13:12] == 2'b10, stage_rails[13:12], 2'b10);

    // random traffic
    for (int j = 0; j < 3000; j++)
      cycle(($urandom_range(0, 63) == 0), $urandom_range(0, 1), rand_val(), rand_val());

    // R8: inject both rails high into stage 0
    cycle(1, 0, 2'b00, 2'b00);
    cycle(0, 1, 2'b11, 2'b00);   // enters tick 0, stage 0 captures 11
    cycle(0, 0, 2'b00, 2'b00);
    check("R8", enc_err == 1'b1, enc_err, 1);
    repeat (6) cycle(0, 1, 2'b00, 2'b00);
    check("R8", enc_err == 1'b1, enc_err, 1);
    cycle(1, 0, 2'b00, 2'b00);
    check("R9", enc_err == 1'b0, enc_err, 0);
    check("R9", phase == 4'b0000, phase, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule